// File: doc/BRIEF.md
# Two-Lane Folded 16-Point FFT

This block computes a 16-point complex discrete Fourier transform on a continuous stream. Two complex samples go in and two come out on every clock. The butterflies of each column of a radix-2 decimation-in-frequency flow graph are folded onto one butterfly unit. Every unit does useful work on every cycle of a frame. Between columns, a delay-and-swap network pairs up the samples for the next column. A twiddle rotation follows each butterfly except the last.

A frame occupies eight consecutive input cycles and its first cycle carries a start strobe. Lane a carries sample n and lane b carries sample n+8. The result frame also occupies eight cycles, with bins in bit-reversed order. Each column halves its results, so the outputs are the transform divided by 16.

The stream has no ready signal and applies no back-pressure. The block accepts an input pair on every cycle where in_valid is high. Each output pair is present for exactly one cycle, so the consumer must take every pair flagged by out_valid. Frames may follow each other with no gap, or with idle cycles of any length between them.

Top module: `fft16_dual_lane`

## Requirements
- R1: While reset is held, and after its release until the first result frame, out_valid and out_sof are low.
- R2: An input frame is the cycle with in_sof and in_valid both high, followed by seven more cycles with in_valid high and in_sof low. In cycle n (0..7), lane a holds sample n and lane b holds sample n+8. Each real and imaginary part is a 16-bit two's-complement value with 15 fraction bits.
- R3: out_sof and out_valid rise 11 clock cycles after the cycle that carried in_sof. out_valid then stays high for exactly 8 cycles, and out_sof is high only in the first of them.
- R4: In output cycle s (0..7), lane a holds bin r(s) and lane b holds bin r(s)+8, where r(s) reverses the three bits of s.
- R5: For general inputs that are not near full scale, each output part is within 8 LSB of the exact transform X[k] = sum of x[n]·e^(-j2πnk/16), divided by 16.
- R6: Frames may be back to back or separated by idle cycles. Lane values on cycles with in_valid low are ignored, and out_valid is never high outside a result frame.
- R7: Each halving rounds half up, so a frame of 16 equal samples c gives exactly c in bin 0 and exactly zero in all other bins.
- R8: A frame with sample 0 equal to (16000, -16000) and all other samples zero gives exactly (1000, -1000) in every bin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input pair present this cycle |
| in_sof | input | 1 | First pair of an input frame |
| in_a_re | input | 16 | Lane a real part, sample n |
| in_a_im | input | 16 | Lane a imaginary part, sample n |
| in_b_re | input | 16 | Lane b real part, sample n+8 |
| in_b_im | input | 16 | Lane b imaginary part, sample n+8 |
| out_valid | output | 1 | Output pair present this cycle |
| out_sof | output | 1 | First pair of a result frame |
| out_a_re | output | 16 | Lane a real part, bin r(s) |
| out_a_im | output | 16 | Lane a imaginary part, bin r(s) |
| out_b_re | output | 16 | Lane b real part, bin r(s)+8 |
| out_b_im | output | 16 | Lane b imaginary part, bin r(s)+8 |

## Verification
The bench runs back-to-back frames and frames separated by idle cycles filled with garbage lane values. A swap network that takes its block phase from a free-running count instead of the frame start would mix the tail of one frame into the head of the next. Bins are compared after undoing the bit-reversed order. A wrong twiddle sign or index, or swapped lanes, moves energy into the wrong bins of the tone and random frames. The constant and impulse frames are checked bit-exactly, so floor rounding in the halving or a rounding error on the zero-angle path shows up as a one-LSB error. Per-frame latency and valid-run counts catch an extra or missing delay register, and catch stray valid cycles between frames.

// File: rtl/fft16_pkg.sv
package fft16_pkg;
  localparam int NPTS = 16;
  localparam int HALF = NPTS / 2;
  localparam int NSTG = $clog2(NPTS);
  localparam int IDXW = $clog2(HALF);
  localparam int TWW  = 16;

  typedef logic [IDXW-1:0] idx_t;

  // cos(2*pi*k/16) scaled by 2^15, clipped to the positive limit
  function automatic logic signed [TWW-1:0] tw_cos(input idx_t k);
    case (k)
      3'd0:    return 16'sd32767;
      3'd1:    return 16'sd30274;
      3'd2:    return 16'sd23170;
      3'd3:    return 16'sd12540;
      3'd4:    return 16'sd0;
      3'd5:    return -16'sd12540;
      3'd6:    return -16'sd23170;
      default: return -16'sd30274;
    endcase
  endfunction

  // sin(2*pi*k/16) scaled by 2^15; the rotation uses cos - j*sin
  function automatic logic signed [TWW-1:0] tw_sin(input idx_t k);
    case (k)
      3'd0:    return 16'sd0;
      3'd1:    return 16'sd12540;
      3'd2:    return 16'sd23170;
      3'd3:    return 16'sd30274;
      3'd4:    return 16'sd32767;
      3'd5:    return 16'sd30274;
      3'd6:    return 16'sd23170;
      default: return 16'sd12540;
    endcase
  endfunction
endpackage

// File: rtl/fft16_dly.sv
module fft16_dly #(
  parameter int W   = 8,
  parameter int DLY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [DLY];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < DLY; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[DLY-1];
endmodule

// File: rtl/fft16_comm.sv
module fft16_comm
  import fft16_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DLY = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic                 sof_i,
  input  logic signed [DW-1:0] u_re,
  input  logic signed [DW-1:0] u_im,
  input  logic signed [DW-1:0] l_re,
  input  logic signed [DW-1:0] l_im,
  output logic                 v_o,
  output logic                 sof_o,
  output logic signed [DW-1:0] p_re,
  output logic signed [DW-1:0] p_im,
  output logic signed [DW-1:0] q_re,
  output logic signed [DW-1:0] q_im
);
  localparam int SB = $clog2(DLY);

  idx_t cnt, idx;
  logic swap;
  logic [2*DW-1:0] l_dly, sw_top, sw_bot, top_dly;

  // position within the frame, restarted by each frame start
  assign idx  = (sof_i && v_i) ? '0 : cnt;
  assign swap = idx[SB];

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= idx + 1'b1;
  end

  fft16_dly #(.W(2*DW), .DLY(DLY)) u_pre (
    .clk(clk), .rst_n(rst_n), .d({l_re, l_im}), .q(l_dly)
  );

  assign sw_top = swap ? l_dly : {u_re, u_im};
  assign sw_bot = swap ? {u_re, u_im} : l_dly;

  fft16_dly #(.W(2*DW), .DLY(DLY)) u_post (
    .clk(clk), .rst_n(rst_n), .d(sw_top), .q(top_dly)
  );

  fft16_dly #(.W(2), .DLY(DLY)) u_tag (
    .clk(clk), .rst_n(rst_n), .d({v_i, sof_i & v_i}), .q({v_o, sof_o})
  );

  assign {p_re, p_im} = top_dly;
  assign {q_re, q_im} = sw_bot;
endmodule

// File: rtl/fft16_bfly.sv
module fft16_bfly
  import fft16_pkg::*;
#(
  parameter int DW  = 16,
  parameter int STG = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v_i,
  input  logic                 sof_i,
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic                 v_o,
  output logic                 sof_o,
  output logic signed [DW-1:0] x_re,
  output logic signed [DW-1:0] x_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = DW + TWW + 1;
  localparam idx_t MSK = idx_t'((HALF - 1) >> STG);
  localparam logic signed [PW-1:0] RND  = PW'(1 <<< (TWW - 2));
  localparam logic signed [PW-1:0] MAXV = PW'((1 <<< (DW - 1)) - 1);
  localparam logic signed [PW-1:0] MINV = PW'(-(1 <<< (DW - 1)));

  idx_t cnt, idx, ex;

  assign idx = (sof_i && v_i) ? '0 : cnt;
  assign ex  = idx_t'((idx & MSK) << STG);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= idx + 1'b1;
  end

  // halving add and subtract, rounded half up
  logic signed [DW:0] s_re, s_im, d_re, d_im;
  assign s_re = {a_re[DW-1], a_re} + {b_re[DW-1], b_re} + 1'b1;
  assign s_im = {a_im[DW-1], a_im} + {b_im[DW-1], b_im} + 1'b1;
  assign d_re = {a_re[DW-1], a_re} - {b_re[DW-1], b_re} + 1'b1;
  assign d_im = {a_im[DW-1], a_im} - {b_im[DW-1], b_im} + 1'b1;

  logic signed [DW-1:0] hs_re, hs_im, hd_re, hd_im;
  assign hs_re = s_re[DW:1];
  assign hs_im = s_im[DW:1];
  assign hd_re = d_re[DW:1];
  assign hd_im = d_im[DW:1];

  // rotation of the difference by cos - j*sin
  logic signed [PW-1:0] dre, die, ce, se, pr_re, pr_im, sh_re, sh_im;
  logic signed [DW-1:0] rt_re, rt_im;

  assign dre = PW'(hd_re);
  assign die = PW'(hd_im);
  assign ce  = PW'(tw_cos(ex));
  assign se  = PW'(tw_sin(ex));

  assign pr_re = dre * ce + die * se + RND;
  assign pr_im = die * ce - dre * se + RND;
  assign sh_re = pr_re >>> (TWW - 1);
  assign sh_im = pr_im >>> (TWW - 1);

  always_comb begin
    if (sh_re > MAXV)      rt_re = MAXV[DW-1:0];
    else if (sh_re < MINV) rt_re = MINV[DW-1:0];
    else                   rt_re = sh_re[DW-1:0];
    if (sh_im > MAXV)      rt_im = MAXV[DW-1:0];
    else if (sh_im < MINV) rt_im = MINV[DW-1:0];
    else                   rt_im = sh_im[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      sof_o <= 1'b0;
    end else begin
      v_o   <= v_i;
      sof_o <= sof_i & v_i;
    end
  end

  // the zero angle skips the multiplier so unit gain stays exact
  always_ff @(posedge clk) begin
    x_re <= hs_re;
    x_im <= hs_im;
    y_re <= (ex == '0) ? hd_re : rt_re;
    y_im <= (ex == '0) ? hd_im : rt_im;
  end

  // a stage never flags a frame start on an empty slot (R3)
  p_stage_tag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sof_o |-> v_o);
endmodule

// File: rtl/fft16_dual_lane.sv
module fft16_dual_lane
  import fft16_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic signed [DW-1:0] in_a_re,
  input  logic signed [DW-1:0] in_a_im,
  input  logic signed [DW-1:0] in_b_re,
  input  logic signed [DW-1:0] in_b_im,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic signed [DW-1:0] out_a_re,
  output logic signed [DW-1:0] out_a_im,
  output logic signed [DW-1:0] out_b_re,
  output logic signed [DW-1:0] out_b_im
);
  logic [NSTG:0]        sv, ss;
  logic signed [DW-1:0] sar [NSTG+1];
  logic signed [DW-1:0] sai [NSTG+1];
  logic signed [DW-1:0] sbr [NSTG+1];
  logic signed [DW-1:0] sbi [NSTG+1];

  assign sv[0]  = in_valid;
  assign ss[0]  = in_sof;
  assign sar[0] = in_a_re;
  assign sai[0] = in_a_im;
  assign sbr[0] = in_b_re;
  assign sbi[0] = in_b_im;

  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    if (k == 0) begin : g_head
      fft16_bfly #(.DW(DW), .STG(k)) u_bf (
        .clk(clk), .rst_n(rst_n), .v_i(sv[k]), .sof_i(ss[k]),
        .a_re(sar[k]), .a_im(sai[k]), .b_re(sbr[k]), .b_im(sbi[k]),
        .v_o(sv[k+1]), .sof_o(ss[k+1]),
        .x_re(sar[k+1]), .x_im(sai[k+1]), .y_re(sbr[k+1]), .y_im(sbi[k+1])
      );
    end else begin : g_fold
      logic                 cv, cs;
      logic signed [DW-1:0] pr, pi, qr, qi;

      fft16_comm #(.DW(DW), .DLY(HALF >> k)) u_cm (
        .clk(clk), .rst_n(rst_n), .v_i(sv[k]), .sof_i(ss[k]),
        .u_re(sar[k]), .u_im(sai[k]), .l_re(sbr[k]), .l_im(sbi[k]),
        .v_o(cv), .sof_o(cs),
        .p_re(pr), .p_im(pi), .q_re(qr), .q_im(qi)
      );

      fft16_bfly #(.DW(DW), .STG(k)) u_bf (
        .clk(clk), .rst_n(rst_n), .v_i(cv), .sof_i(cs),
        .a_re(pr), .a_im(pi), .b_re(qr), .b_im(qi),
        .v_o(sv[k+1]), .sof_o(ss[k+1]),
        .x_re(sar[k+1]), .x_im(sai[k+1]), .y_re(sbr[k+1]), .y_im(sbi[k+1])
      );
    end
  end

  assign out_valid = sv[NSTG];
  assign out_sof   = ss[NSTG];
  assign out_a_re  = sar[NSTG];
  assign out_a_im  = sai[NSTG];
  assign out_b_re  = sbr[NSTG];
  assign out_b_im  = sbi[NSTG];

  // frame tracking for the stream checks
  idx_t icnt, ocnt;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icnt <= '0;
      ocnt <= '0;
    end else begin
      if (in_valid && in_sof) icnt <= idx_t'(HALF - 1);
      else if (icnt != '0)    icnt <= icnt - 1'b1;
      if (out_valid && out_sof) ocnt <= idx_t'(HALF - 1);
      else if (ocnt != '0)      ocnt <= ocnt - 1'b1;
    end
  end

  p_sof_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_sof |-> in_valid);

  p_frame_unbroken_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt != '0) |-> (in_valid && !in_sof));

  p_result_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ocnt != '0) |-> (out_valid && !out_sof));

  p_no_stray_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && ocnt == '0) |-> out_sof);
endmodule

// File: tb/fft16_dual_lane_bench.sv
`timescale 1ns/1ps
module fft16_dual_lane_bench;
  localparam int TOL  = 8;
  localparam int LAT  = 11;
  localparam int MAXF = 32;
  localparam int NPAT = 8;
  // kind (2 tone, 3 random, 4 real cosine), amplitude, bin, idle cycles before
  localparam int PAT [0:NPAT-1][0:3] = '{
    '{2, 15000, 1, 0}, '{2, 12000, 5, 0}, '{3, 16000, 0, 0}, '{4, 14000, 3, 3},
    '{3,  9000, 0, 1}, '{2, -11000, 7, 0}, '{4, 8000, 6, 5}, '{3, 16000, 0, 0}
  };

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_sof, out_valid, out_sof;
  logic signed [15:0] in_a_re, in_a_im, in_b_re, in_b_im;
  logic signed [15:0] out_a_re, out_a_im, out_b_re, out_b_im;

  fft16_dual_lane u_fft16_dual_lane (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_a_re(in_a_re), .in_a_im(in_a_im), .in_b_re(in_b_re), .in_b_im(in_b_im),
    .out_valid(out_valid), .out_sof(out_sof),
    .out_a_re(out_a_re), .out_a_im(out_a_im), .out_b_re(out_b_re), .out_b_im(out_b_im)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errs = 0;
  bit done = 1'b0;
  int seed = 7;
  int xr [16], xi [16];
  int sr [MAXF][16], si [MAXF][16], cr [MAXF][16], ci [MAXF][16];
  int tol_f [MAXF], tin [MAXF], tout [MAXF];
  string tag_f [MAXF];
  int nsent = 0, nout = 0, slot = 0, vcyc = 0, stray = 0;

  function automatic int lcg(input int lim);
    seed = seed * 1103515245 + 12345;
    return ((seed >> 8) % (2 * lim + 1)) - lim;
  endfunction

  function automatic int rev3(input int s);
    return ((s & 1) << 2) | (s & 2) | ((s >> 2) & 1);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // result capture, undoing the bit-reversed order (R4)
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      vcyc++;
      if (out_sof) begin
        if (nout < MAXF) tout[nout] = cyc;
        nout++;
        slot = 0;
      end
      if (nout == 0 || nout > MAXF || slot > 7) stray++;
      else begin
        cr[nout-1][rev3(slot)]     = int'(out_a_re);
        ci[nout-1][rev3(slot)]     = int'(out_a_im);
        cr[nout-1][rev3(slot) + 8] = int'(out_b_re);
        ci[nout-1][rev3(slot) + 8] = int'(out_b_im);
        slot++;
      end
    end
  end

  task automatic idle_cycle();
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_a_re  = 16'(lcg(30000));
    in_a_im  = 16'(lcg(30000));
    in_b_re  = 16'(lcg(30000));
    in_b_im  = 16'(lcg(30000));
  endtask

  task automatic send(input int gap, input int tol, input string tag);
    for (int g = 0; g < gap; g++) idle_cycle();
    for (int n = 0; n < 8; n++) begin
      @(negedge clk);
      if (n == 0) tin[nsent] = cyc;
      in_valid = 1'b1;
      in_sof   = (n == 0);
      in_a_re  = 16'(xr[n]);
      in_a_im  = 16'(xi[n]);
      in_b_re  = 16'(xr[n+8]);
      in_b_im  = 16'(xi[n+8]);
    end
    for (int n = 0; n < 16; n++) begin
      sr[nsent][n] = xr[n];
      si[nsent][n] = xi[n];
    end
    tol_f[nsent] = tol;
    tag_f[nsent] = tag;
    nsent++;
  endtask

  task automatic gen(input int kind, input int amp, input int bin);
    for (int n = 0; n < 16; n++) begin
      real ang;
      ang = 2.0 * 3.14159265358979 * real'(bin * n) / 16.0;
      case (kind)
        0: begin xr[n] = amp; xi[n] = amp / 3; end
        1: begin xr[n] = (n == 0) ? amp : 0; xi[n] = (n == 0) ? -amp : 0; end
        2: begin xr[n] = int'(real'(amp) * $cos(ang)); xi[n] = int'(real'(amp) * $sin(ang)); end
        3: begin xr[n] = lcg(amp); xi[n] = lcg(amp); end
        default: begin xr[n] = int'(real'(amp) * $cos(ang)); xi[n] = 0; end
      endcase
    end
  endtask

  task automatic verify_frame(input int f);
    for (int k = 0; k < 16; k++) begin
      real re, im;
      int er, ei;
      re = 0.0;
      im = 0.0;
      for (int n = 0; n < 16; n++) begin
        real a;
        a = 2.0 * 3.14159265358979 * real'((n * k) % 16) / 16.0;
        re += real'(sr[f][n]) * $cos(a) + real'(si[f][n]) * $sin(a);
        im += real'(si[f][n]) * $cos(a) - real'(sr[f][n]) * $sin(a);
      end
      er = int'(re / 16.0);
      ei = int'(im / 16.0);
      chk((cr[f][k] - er <= tol_f[f]) && (er - cr[f][k] <= tol_f[f]),
          tag_f[f], $sformatf("frame %0d bin %0d real", f, k), cr[f][k], er);
      chk((ci[f][k] - ei <= tol_f[f]) && (ei - ci[f][k] <= tol_f[f]),
          tag_f[f], $sformatf("frame %0d bin %0d imag", f, k), ci[f][k], ei);
    end
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      chk(1'b0, "R3", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_sof = 1'b0;
    in_a_re = '0; in_a_im = '0; in_b_re = '0; in_b_im = '0;
    repeat (4) @(negedge clk);
    chk(!out_valid && !out_sof, "R1", "outputs during reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (3) idle_cycle();
    chk(!out_valid && !out_sof, "R1", "outputs after reset", int'(out_valid), 0);

    // directed exact cases, back to back (R7, R8)
    gen(0, 12000, 0);  send(0, 0, "R7");
    gen(0, -12345, 0); send(0, 0, "R7");
    gen(1, 16000, 0);  send(0, 0, "R8");

    // vector table: tones, random data, cosines, gaps of 0..5 cycles
    for (int i = 0; i < NPAT; i++) begin
      gen(PAT[i][0], PAT[i][1], PAT[i][2]);
      send(PAT[i][3], TOL, "R4 R5 R6");
    end
    repeat (40) idle_cycle();

    chk(nout == nsent, "R3", "result frame count", nout, nsent);
    chk(vcyc == 8 * nsent, "R3", "valid cycle count", vcyc, 8 * nsent);
    chk(stray == 0, "R6", "valid cycles outside frames", stray, 0);
    for (int f = 0; f < nsent && f < nout; f++) begin
      chk(tout[f] - tin[f] == LAT, "R3", $sformatf("frame %0d latency", f),
          tout[f] - tin[f], LAT);
      verify_frame(f);
    end
    // R2 is exercised by every frame's lane layout above
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule